// File: doc/BRIEF.md
# Serial Memory Bus Address Front-End

This block sits at the two-wire serial bus pins of a serial memory whose address space is 11 bits wide. It brings the clock and data lines into the system clock domain, recognises the bus start and stop conditions, and shifts in the first byte that follows a start. That byte carries a 4-bit device-type code, three high-order memory address bits and a direction flag. When the type code matches, the block answers with an acknowledge by enabling its open-drain data driver for the ninth bus clock.

After an acknowledged address byte, the block hands the three captured address bits (word address bits 10 down to 8) and the direction to a downstream memory controller. It does this with a single-cycle strobe and keeps a selected status flag high until the transfer ends. The three address bits are not compared with any strap inputs. All eight codes select the device and are simply forwarded. Word-address bytes, data transfer and storage belong to the downstream logic.

The system clock must run at least four times faster than the bus clock. Both lines pass through a two-flop synchronizer before edge detection.

Top module: `sermem_addr_slave`

## Requirements
- R1: Before a START has been seen, the block ignores all bus activity: clocking in a byte `8'hA5` gives no acknowledge and no strobe.
- R2: A START is a falling edge of SDA while SCL is high. A START at any point, including a repeated START mid-byte or while selected, drops `sel_o`, releases SDA and restarts address-byte reception with an empty shift register.
- R3: A STOP is a rising edge of SDA while SCL is high. It returns the block to idle: `sel_o` low, `sda_oe_o` low, and later bits without a new START are ignored.
- R4: Address bits are sampled on rising SCL edges, most significant bit first. An SDA change while SCL is high is only ever a START or a STOP and is never taken as data.
- R5: The device responds only when address-byte bits 7:4 equal `4'b1010`. On any other value it gives no acknowledge and no strobe, and it waits for the next START.
- R6: On a match, `sda_oe_o` (1 pulls SDA low) rises after the falling SCL edge that ends bit 8. It is high while SCL is high in the ninth clock, and it falls after the falling SCL edge that ends the ninth clock.
- R7: Address-byte bits 3, 2 and 1 appear on `hi_addr_o[2]`, `hi_addr_o[1]` and `hi_addr_o[0]` (memory address a10, a9, a8). All eight codes are accepted.
- R8: Address-byte bit 0 appears on `rd_o`: 1 means read, 0 means write.
- R9: `strobe_o` pulses for exactly one system clock, in the cycle the acknowledge is released, and `hi_addr_o`/`rd_o` are valid then. `sel_o` is high from that cycle until the next STOP or START.
- R10: While selected, further bytes on the bus produce no acknowledge and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| strobe_o | output | 1 | One-cycle pulse after an acknowledged address byte |
| hi_addr_o | output | 3 | Captured memory address bits 10:8 |
| rd_o | output | 1 | Captured direction, 1 read, 0 write |
| sel_o | output | 1 | Device selected until STOP or START |

## Verification
The address byte is driven with matching type codes across all eight high-address values and both directions, so that a swapped or shifted capture field shows up as a wrong scoreboard item. Non-matching type codes and a byte sent with no preceding START separate type decoding from start gating. Repeated STARTs in mid-byte and while selected, and a STOP in mid-byte, show whether partial state is discarded. A data byte sent while selected shows that acknowledge and strobe are tied only to the address phase.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned TYPE_W   = 4;
  localparam int unsigned HI_W     = 3;
  localparam int unsigned CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [TYPE_W-1:0] DEV_TYPE = 4'b1010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_SEL
  } fe_state_e;
endpackage

// File: rtl/sermem_line_sync.sv
module sermem_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    // STAGES sync flops plus one history flop for edge detection
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-1:0], line_i[g]};
    end
    assign level_o[g] = pipe_q[STAGES-1];
    assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[g]  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
  end
endmodule

// File: rtl/sermem_cond_det.sv
module sermem_cond_det (
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // R2 / R3: data edges with the clock high are conditions, never data (R4)
  assign start_o = scl_lvl_i & sda_fall_i;
  assign stop_o  = scl_lvl_i & sda_rise_i;
endmodule

// File: rtl/sermem_addr_fsm.sv
module sermem_addr_fsm
  import sermem_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_lvl_i,
  output logic            oe_o,
  output logic            strobe_o,
  output logic [HI_W-1:0] hi_o,
  output logic            rd_o,
  output logic            sel_o
);
  fe_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sreg_q;

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sreg_q   <= '0;
      oe_o     <= 1'b0;
      strobe_o <= 1'b0;
      hi_o     <= '0;
      rd_o     <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (start_i) begin
        st_q   <= ST_ADDR;
        cnt_q  <= '0;
        sreg_q <= '0;
        oe_o   <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise_i && cnt_q != CNT_FULL) begin
              sreg_q <= {sreg_q[BYTE_W-2:0], sda_lvl_i};
              cnt_q  <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_FULL) begin
              if (sreg_q[BYTE_W-1 -: TYPE_W] == DEV_TYPE) begin
                st_q <= ST_ACK;
                oe_o <= 1'b1;
                hi_o <= sreg_q[HI_W:1];
                rd_o <= sreg_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              oe_o     <= 1'b0;
              strobe_o <= 1'b1;
              st_q     <= ST_SEL;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sel_o = (st_q == ST_SEL);
endmodule

// File: rtl/sermem_addr_slave.sv
module sermem_addr_slave
  import sermem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  output logic            strobe_o,
  output logic [HI_W-1:0] hi_addr_o,
  output logic            rd_o,
  output logic            sel_o
);
  logic [1:0] lvl, rise, fall;
  logic       scl_lvl, start_det, stop_det;

  sermem_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i ({scl_i, sda_i}),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign scl_lvl = lvl[1];

  sermem_cond_det u_cond (
    .scl_lvl_i (scl_lvl),
    .sda_rise_i(rise[0]),
    .sda_fall_i(fall[0]),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  sermem_addr_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .scl_rise_i(rise[1]),
    .scl_fall_i(fall[1]),
    .sda_lvl_i (lvl[0]),
    .oe_o      (sda_oe_o),
    .strobe_o  (strobe_o),
    .hi_o      (hi_addr_o),
    .rd_o      (rd_o),
    .sel_o     (sel_o)
  );
endmodule

// File: rtl/sermem_addr_chk.sv
module sermem_addr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_lvl_i,
  input logic start_i,
  input logic stop_i,
  input logic oe_i,
  input logic strobe_i,
  input logic sel_i
);
  a_r6_ack_starts_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_i) |-> !$past(scl_lvl_i));

  a_r9_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> !strobe_i);

  a_r9_strobe_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> ($past(oe_i) && !oe_i && sel_i));

  a_r3_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!sel_i && !oe_i));

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!sel_i && !oe_i && !strobe_i));

  a_r10_no_drive_when_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> !oe_i);
endmodule

bind sermem_addr_slave sermem_addr_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_lvl_i(scl_lvl),
  .start_i  (start_det),
  .stop_i   (stop_det),
  .oe_i     (sda_oe_o),
  .strobe_i (strobe_o),
  .sel_i    (sel_o)
);

// File: tb/tb_sermem_addr_slave.sv
module tb_sermem_addr_slave;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe_o, strobe_o, rd_o, sel_o;
  logic [2:0] hi_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_q[$];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe_o;

  sermem_addr_slave dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe_o),
    .strobe_o (strobe_o),
    .hi_addr_o(hi_addr_o),
    .rd_o     (rd_o),
    .sel_o    (sel_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop expected items on every strobe (R7, R8, R9, R4)
  always @(negedge clk) begin
    if (rst_ni && strobe_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", {hi_addr_o, rd_o}, 0);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(hi_addr_o == e[3:1], "R7 R4 hi_addr capture", hi_addr_o, e[3:1]);
        chk(rd_o == e[0], "R8 direction capture", rd_o, e[0]);
        chk(sel_o == 1'b1, "R9 sel with strobe", sel_o, 1);
      end
    end
  end

  task automatic start_c();
    scl_m = 1'b0; wt(Q);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic stop_c();
    scl_m = 1'b0; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input bit b, output logic oe_hi);
    scl_m = 1'b0; wt(Q);
    sda_m = b;    wt(Q);
    scl_m = 1'b1; wt(Q);
    oe_hi = sda_oe_o;
    wt(Q);
    scl_m = 1'b0;
  endtask

  // Driver: sends a byte plus the ninth clock; pushes the expected item on a match
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    logic oe_hi;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], oe_hi);
      chk(oe_hi == 1'b0, {tag, " R4 no drive during data bit"}, oe_hi, 0);
    end
    if (exp_ack) exp_q.push_back({b[3:1], b[0]});
    send_bit(1'b1, oe_hi);
    chk(oe_hi == exp_ack, {tag, " R6 ack in ninth clock"}, oe_hi, exp_ack);
    wt(Q);
    chk(sda_oe_o == 1'b0, {tag, " R6 ack released"}, sda_oe_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic oe_tmp;
    wt(3);
    rst_ni = 1'b1;
    wt(4);
    chk(sda_oe_o == 1'b0, "R6 reset oe", sda_oe_o, 0);
    chk(strobe_o == 1'b0, "R9 reset strobe", strobe_o, 0);
    chk(sel_o == 1'b0, "R9 reset sel", sel_o, 0);

    // R1: no START yet
    send_byte(8'hA5, 1'b0, "R1 no start");
    stop_c();

    // basic select, then a data byte while selected (R10), STOP (R3)
    start_c();
    send_byte(8'hA5, 1'b1, "R5 match");
    chk(sel_o == 1'b1, "R9 sel after ack", sel_o, 1);
    send_byte(8'h00, 1'b0, "R10 data byte");
    chk(sel_o == 1'b1, "R10 sel held", sel_o, 1);
    stop_c();
    wt(Q);
    chk(sel_o == 1'b0, "R3 sel after stop", sel_o, 0);

    // R7 / R8: every high-address code, both directions
    for (int c = 0; c < 8; c++) begin
      start_c();
      send_byte({4'b1010, c[2:0], c[0] ^ c[1]}, 1'b1, "R7 code sweep");
      stop_c();
    end

    // R5: mismatching type codes
    start_c();
    send_byte(8'hB4, 1'b0, "R5 mismatch B");
    send_byte(8'hA4, 1'b0, "R5 wait for start");
    stop_c();
    start_c();
    send_byte(8'h2B, 1'b0, "R5 mismatch 2");
    stop_c();
    chk(sel_o == 1'b0, "R5 not selected", sel_o, 0);

    // R2: repeated START mid-byte, then while selected
    start_c();
    for (int i = 0; i < 4; i++) send_bit(i[0] ? 1'b0 : 1'b1, oe_tmp);
    start_c();
    send_byte(8'hA6, 1'b1, "R2 restart mid-byte");
    start_c();
    chk(sel_o == 1'b0, "R2 sel cleared by start", sel_o, 0);
    send_byte(8'hAF, 1'b1, "R2 restart selected");
    stop_c();

    // R3: STOP mid-byte then bits without START
    start_c();
    for (int i = 0; i < 3; i++) send_bit(1'b1, oe_tmp);
    stop_c();
    send_byte(8'hA4, 1'b0, "R3 after stop");
    stop_c();

    wt(4 * Q);
    chk(exp_q.size() == 0, "R9 all strobes seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule